// File: doc/BRIEF.md
# Segmented Address Translator with Access Protection

This block turns a logical address, given as a segment number and an offset inside that segment, into a physical address. It looks the segment up in a small on-chip descriptor table. Each descriptor holds a base, a limit, a live bit and three permission bits. Before it adds the base, the block checks the request for legality and for the access rights of the request. It then returns either a physical address or a fault code.

Two configuration registers select which descriptors a request can reach. A window start register picks the table row that segment 0 maps to. A segment count register sets how many segments are legal. Changing the window start moves the whole context to another group of rows, so a context switch needs only one register write.

Descriptors are loaded through a separate write port, one row per cycle. Every request gets exactly one registered response, one cycle later.

Top module: `segx_top`

## Requirements
- R1: After reset the response is idle (`rsp_valid` 0, address 0, fault 0). The segment count is 0, the window start is 0 and every descriptor is cleared, so a first request reports fault code 1.
- R2: A request with `req_valid` high in cycle N gives `rsp_valid` high in cycle N+1 only. A cycle without a request gives `rsp_valid` low in the next cycle.
- R3: If the segment number is greater than or equal to the segment count, the fault code is 1. A count of 8 or more makes every segment number pass this check.
- R4: If the selected descriptor has its live bit at 0, the fault code is 2.
- R5: If the offset is greater than or equal to the descriptor limit, the fault code is 3. A limit of 0 rejects every offset.
- R6: Access kinds are encoded 0 read, 1 write, 2 execute and 3 reserved. Permission bits are bit 0 read, bit 1 write and bit 2 execute. An access whose bit is clear, or any reserved access, gives fault code 4.
- R7: A request that passes every check gives fault code 0 and the address (base + offset) modulo 2^24.
- R8: The checks run in the order count, live bit, limit, permission. Only the first check that fails is reported.
- R9: The descriptor used is table row (window start + segment number) modulo 16.
- R10: A request in the same cycle as a descriptor write or a configuration write uses the contents from before that write. The new contents apply from the next cycle.
- R11: While a response carries a fault, or no response is valid, `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Load the window start and segment count registers |
| cfg_base | input | 4 | New window start (table row of segment 0) |
| cfg_len | input | 4 | New segment count |
| tbl_wr_en | input | 1 | Write one descriptor row |
| tbl_wr_row | input | 4 | Row to write |
| tbl_wr_live | input | 1 | Live bit of the descriptor |
| tbl_wr_perm | input | 3 | Permission bits: bit 0 read, bit 1 write, bit 2 execute |
| tbl_wr_limit | input | 16 | Segment limit |
| tbl_wr_base | input | 24 | Segment physical base |
| req_valid | input | 1 | Translation request |
| req_seg | input | 3 | Segment number |
| req_off | input | 16 | Offset within the segment |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 24 | Physical address, 0 on a fault |
| rsp_fault | output | 3 | 0 none, 1 count, 2 not live, 3 limit, 4 permission |

## Verification
On every cycle the assertions check the following: the response follows the request with one cycle of latency, an idle cycle follows an idle cycle, the address is 0 whenever a fault is present or no response is valid, and an out-of-count segment reports fault code 1. They also check that each descriptor write lands in its row in the next cycle. The bench's scenarios are the only way to show the rest: the address arithmetic and its wrap, the order in which faults take priority across all combinations of live bit, limit and permission, the mapping of window start to row, and the use of the old contents when a write and a request share a cycle.

// File: rtl/seg_pkg.sv
package seg_pkg;
    parameter int SEG_W = 3;
    parameter int OFF_W = 16;
    parameter int PA_W  = 24;
    parameter int ROW_W = 4;
    localparam int ROWS  = 1 << ROW_W;
    localparam int LEN_W = SEG_W + 1;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_LENGTH  = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_LIMIT   = 3'd3,
        FLT_PERM    = 3'd4
    } fault_e;

    typedef struct packed {
        logic             live;
        logic [2:0]       perm;   // bit0 read, bit1 write, bit2 execute
        logic [OFF_W-1:0] limit;
        logic [PA_W-1:0]  base;
    } seg_desc_t;
endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  seg_desc_t        wr_desc,
    input  logic [ROW_W-1:0] rd_row,
    output seg_desc_t        rd_desc
);
    seg_desc_t rows_q [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        seg_desc_t row_d;
        always_comb begin
            row_d = rows_q[g];
            if (wr_en && (wr_row == ROW_W'(g))) begin
                row_d = wr_desc;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rows_q[g] <= '0;
            end else begin
                rows_q[g] <= row_d;
            end
        end
    end

    // The read is taken from the registered rows, so a write lands one cycle later.
    assign rd_desc = rows_q[rd_row];

    p_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rows_q[$past(wr_row)] == $past(wr_desc))
        else $error("descriptor write not stored");
endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_pkg::*;
(
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       kind,
    input  logic [LEN_W-1:0] seg_count,
    input  seg_desc_t        desc,
    output fault_e           fault,
    output logic [PA_W-1:0]  paddr
);
    logic allowed;

    always_comb begin
        case (kind)
            ACC_READ:  allowed = desc.perm[0];
            ACC_WRITE: allowed = desc.perm[1];
            ACC_EXEC:  allowed = desc.perm[2];
            default:   allowed = 1'b0;
        endcase
    end

    // Fixed priority: count, live bit, limit, permission.
    always_comb begin
        fault = FLT_NONE;
        paddr = '0;
        if ({1'b0, seg} >= seg_count) begin
            fault = FLT_LENGTH;
        end else if (!desc.live) begin
            fault = FLT_INVALID;
        end else if (off >= desc.limit) begin
            fault = FLT_LIMIT;
        end else if (!allowed) begin
            fault = FLT_PERM;
        end else begin
            paddr = desc.base + PA_W'(off);
        end
    end
endmodule

// File: rtl/segx_top.sv
module segx_top
    import seg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [ROW_W-1:0] cfg_base,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             tbl_wr_en,
    input  logic [ROW_W-1:0] tbl_wr_row,
    input  logic             tbl_wr_live,
    input  logic [2:0]       tbl_wr_perm,
    input  logic [OFF_W-1:0] tbl_wr_limit,
    input  logic [PA_W-1:0]  tbl_wr_base,
    input  logic             req_valid,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic [1:0]       req_kind,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [2:0]       rsp_fault
);
    typedef struct packed {
        logic             rsp_valid;
        fault_e           fault;
        logic [PA_W-1:0]  paddr;
        logic [ROW_W-1:0] win_base;
        logic [LEN_W-1:0] seg_count;
    } state_t;

    state_t    st_d, st_q;
    seg_desc_t wr_desc, rd_desc;
    logic [ROW_W-1:0] rd_row;
    fault_e    chk_fault;
    logic [PA_W-1:0] chk_paddr;

    assign wr_desc = '{live: tbl_wr_live, perm: tbl_wr_perm,
                       limit: tbl_wr_limit, base: tbl_wr_base};
    assign rd_row  = st_q.win_base + ROW_W'(req_seg);

    seg_table u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_row  (tbl_wr_row),
        .wr_desc (wr_desc),
        .rd_row  (rd_row),
        .rd_desc (rd_desc)
    );

    seg_check u_check (
        .seg       (req_seg),
        .off       (req_off),
        .kind      (req_kind),
        .seg_count (st_q.seg_count),
        .desc      (rd_desc),
        .fault     (chk_fault),
        .paddr     (chk_paddr)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.fault     = FLT_NONE;
        st_d.paddr     = '0;
        if (req_valid) begin
            st_d.fault = chk_fault;
            st_d.paddr = chk_paddr;
        end
        if (cfg_wr_en) begin
            st_d.win_base  = cfg_base;
            st_d.seg_count = cfg_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rsp_valid: 1'b0, fault: FLT_NONE, paddr: '0,
                      win_base: '0, seg_count: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_paddr = st_q.paddr;
    assign rsp_fault = st_q.fault;

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid)
        else $error("response missing after request");

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid)
        else $error("response without request");

    p_zero_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_valid || rsp_fault != 3'd0) |-> rsp_paddr == '0)
        else $error("address leaked on fault or idle");

    p_count_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} >= st_q.seg_count)) |=> rsp_fault == 3'd1)
        else $error("count check not reported first");

    p_code_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fault <= 3'd4)
        else $error("undefined fault code");
endmodule

// File: tb/tb_segx_top.sv
`timescale 1ns/1ps
module tb_segx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_base = '0;
    logic [3:0]  cfg_len = '0;
    logic        tbl_wr_en = 1'b0;
    logic [3:0]  tbl_wr_row = '0;
    logic        tbl_wr_live = 1'b0;
    logic [2:0]  tbl_wr_perm = '0;
    logic [15:0] tbl_wr_limit = '0;
    logic [23:0] tbl_wr_base = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_seg = '0;
    logic [15:0] req_off = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic [23:0] rsp_paddr;
    logic [2:0]  rsp_fault;

    always #2 clk = ~clk;

    segx_top dut (.*);

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic        m_live  [16];
    logic [2:0]  m_perm  [16];
    logic [15:0] m_limit [16];
    logic [23:0] m_base  [16];
    logic [3:0]  m_wbase = '0;
    logic [3:0]  m_len = '0;

    function automatic logic [26:0] model(input logic [2:0] s, input logic [15:0] o,
                                          input logic [1:0] k);
        logic [3:0] row;
        logic ok;
        row = m_wbase + {1'b0, s};
        ok = (k == 2'd3) ? 1'b0 : m_perm[row][k];
        if ({1'b0, s} >= m_len)      return {3'd1, 24'd0};
        if (!m_live[row])            return {3'd2, 24'd0};
        if (o >= m_limit[row])       return {3'd3, 24'd0};
        if (!ok)                     return {3'd4, 24'd0};
        return {3'd0, m_base[row] + {8'd0, o}};
    endfunction

    function automatic string tag_of(input logic [2:0] f);
        case (f)
            3'd0: return "R7";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic compare(input string tag, input logic v_exp, input logic [26:0] exp);
        checks++;
        if (rsp_valid !== v_exp || rsp_fault !== exp[26:24] || rsp_paddr !== exp[23:0]) begin
            failures++;
            $display("FAIL %s: got valid=%0b fault=%0d paddr=%h expected valid=%0b fault=%0d paddr=%h",
                     tag, rsp_valid, rsp_fault, rsp_paddr, v_exp, exp[26:24], exp[23:0]);
        end
    endtask

    task automatic write_row(input int r, input logic lv, input logic [2:0] p,
                             input logic [15:0] lim, input logic [23:0] b);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_row = 4'(r); tbl_wr_live = lv;
        tbl_wr_perm = p; tbl_wr_limit = lim; tbl_wr_base = b;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        m_live[r] = lv; m_perm[r] = p; m_limit[r] = lim; m_base[r] = b;
    endtask

    task automatic write_cfg(input logic [3:0] b, input logic [3:0] l);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_base = b; cfg_len = l;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        m_wbase = b; m_len = l;
    endtask

    task automatic request(input logic [2:0] s, input logic [15:0] o,
                           input logic [1:0] k, input string tag);
        logic [26:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_seg = s; req_off = o; req_kind = k;
        exp = model(s, o, k);
        @(negedge clk);
        req_valid = 1'b0;
        compare((tag == "") ? tag_of(exp[26:24]) : tag, 1'b1, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got running expected finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [26:0] exp_old;
        logic [3:0]  bases [3];
        logic [3:0]  lens  [3];
        logic [15:0] offs  [4];
        bases = '{4'd0, 4'd8, 4'd13};
        lens  = '{4'd0, 4'd3, 4'd8};
        for (int i = 0; i < 16; i++) begin
            m_live[i] = 1'b0; m_perm[i] = '0; m_limit[i] = '0; m_base[i] = '0;
        end
        repeat (3) @(negedge clk);
        compare("R1", 1'b0, 27'd0);
        rst_n = 1'b1;
        request(3'd0, 16'd0, 2'd0, "R1");
        @(negedge clk);
        compare("R2", 1'b0, 27'd0);

        for (int i = 0; i < 16; i++) begin
            write_row(i, (i != 5 && i != 13), (i == 15) ? 3'd7 : 3'(i),
                      (i == 2) ? 16'd0 : 16'((i + 1) * 256 + i * 3),
                      (i == 15) ? 24'hFFFF80 : 24'(i * 24'h0F1234 + 24'h000ABC));
        end

        // R9 R3 R4 R5 R6 R7: sweep window, count, segment, kind and offset corners
        foreach (bases[bi]) begin
            foreach (lens[li]) begin
                write_cfg(bases[bi], lens[li]);
                for (int s = 0; s < 8; s++) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [3:0] row;
                        row = m_wbase + 4'(s);
                        offs = '{16'd0, m_limit[row] - 16'd1, m_limit[row], 16'hFFFF};
                        foreach (offs[oi]) request(3'(s), offs[oi], 2'(k), "");
                    end
                end
            end
        end

        // R8: priority with several failing checks at once
        write_cfg(4'd0, 4'd8);
        request(3'd5, 16'hFFFF, 2'd3, "R8");  // not live, over limit, reserved -> 2
        write_row(6, 1'b1, 3'd0, 16'd16, 24'h000100);
        request(3'd6, 16'd16, 2'd0, "R8");    // over limit and no rights -> 3
        write_cfg(4'd0, 4'd5);
        request(3'd5, 16'hFFFF, 2'd3, "R8");  // everything fails -> 1

        // R10: descriptor write and request in the same cycle
        write_cfg(4'd0, 4'd8);
        write_row(1, 1'b1, 3'd1, 16'h1000, 24'h123400);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_row = 4'd1; tbl_wr_live = 1'b1; tbl_wr_perm = 3'd1;
        tbl_wr_limit = 16'h1000; tbl_wr_base = 24'h555500;
        req_valid = 1'b1; req_seg = 3'd1; req_off = 16'h0010; req_kind = 2'd0;
        exp_old = model(3'd1, 16'h0010, 2'd0);
        @(negedge clk);
        tbl_wr_en = 1'b0; req_valid = 1'b0;
        m_base[1] = 24'h555500;
        compare("R10", 1'b1, exp_old);
        request(3'd1, 16'h0010, 2'd0, "R10");

        // R10: configuration write and request in the same cycle
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_base = 4'd0; cfg_len = 4'd1;
        req_valid = 1'b1; req_seg = 3'd1; req_off = 16'h0020; req_kind = 2'd0;
        exp_old = model(3'd1, 16'h0020, 2'd0);
        @(negedge clk);
        cfg_wr_en = 1'b0; req_valid = 1'b0; m_len = 4'd1;
        compare("R10", 1'b1, exp_old);
        request(3'd1, 16'h0020, 2'd0, "R10");

        // R11: idle after a fault shows a zero address
        @(negedge clk);
        compare("R11", 1'b0, 27'd0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule